// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO with Programmable Level Flags

This block buffers 18-bit words between a write clock domain and a read clock domain. A timing mode is chosen while reset is held and cannot change until the next reset. In standard mode the read port acts on request: a word reaches `rdata` only in the read-clock cycle after `rd_en` is seen while data is stored. In fall-through mode the oldest word is moved into the output register without any request. `rd_en` then consumes the word that is shown. The extra output register makes the fall-through capacity one word larger than the RAM.

Back-pressure uses level flags. All flags are active low. In standard mode `wr_flag` means "not full": LOW when full. `rd_flag` means "not empty": LOW when empty. In fall-through mode the same pins act as ready indications: `wr_flag` LOW means a write will be taken, and `rd_flag` LOW means `rdata` holds a valid word. A writer only pulses `wr_en` when `wr_flag` allows it, and a reader only pulses `rd_en` when `rd_flag` allows it. Requests made against the flag are dropped with no effect.

Two loadable thresholds drive the almost-empty flag, which is updated in the read domain, and the almost-full flag, which is updated in the write domain. A half-full flag is updated on the write clock. The pointers cross between domains as Gray code through two-flop synchronizers. The flags can therefore lag the true state, but only in the safe direction.

Top module: `dual_mode_fifo`

## Requirements
- R1: The mode is taken from `mode_fwft` (0 = standard, 1 = fall-through) on clock edges while `rst_n` is LOW. Changing `mode_fwft` after reset has no effect.
- R2: In standard mode a stored word appears on `rdata` only in the read cycle after `rd_en` is accepted. Without a read, `rdata` keeps its value.
- R3: In fall-through mode the oldest stored word appears on `rdata` with no read request, and `rd_flag` goes LOW while it is shown.
- R4: Capacity is 2^AW words in standard mode, where `wr_flag` goes LOW at the last word. In fall-through mode capacity is 2^AW+1 words, where `wr_flag` goes HIGH at the last word.
- R5: A write while full and a read while empty are ignored. Stored data and pointers are left unchanged.
- R6: Reset values are as follows. `wr_flag` is HIGH during reset; after reset it stays HIGH in standard mode and drops LOW in fall-through mode. `rd_flag` is LOW in standard mode and HIGH in fall-through mode. `rdata` is 0, `ae_n` is 0, and `af_n` and `hf_n` are 1.
- R7: Reset returns both thresholds to their default value, which is 31 for a 256-word RAM.
- R8: With `ld` and `wr_en` both HIGH, `wdata[AW-1:0]` is written to a threshold and nothing is stored in the FIFO. The first such cycle writes the empty threshold, and the second writes the full threshold.
- R9: `ae_n` is LOW when the number of words readable (RAM plus output register) is at most the empty threshold. It is updated on `rclk`.
- R10: `af_n` is LOW when the free RAM space is at most the full threshold. It is updated on `wclk`.
- R11: `hf_n` is LOW when more than half of 2^AW words are stored. It is updated on `wclk`.
- R12: Words leave in the order they were written. The Gray pointers change by at most one bit per clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, held for several cycles of both clocks |
| mode_fwft | input | 1 | Mode select, sampled during reset |
| wr_en | input | 1 | Write request |
| ld | input | 1 | Threshold load qualifier for `wr_en` |
| wdata | input | DW | Write data or threshold value |
| rd_en | input | 1 | Read request |
| rdata | output | DW | Output register |
| wr_flag | output | 1 | Not-full (standard) or input-ready, active low (fall-through) |
| rd_flag | output | 1 | Not-empty (standard) or output-ready, active low (fall-through) |
| ae_n | output | 1 | Almost-empty, active low |
| af_n | output | 1 | Almost-full, active low |
| hf_n | output | 1 | Half-full, active low |

## Verification
The bench targets the following corner cases:
- It probes the exact fill thresholds: 31/32 words for almost-empty, 128/129 for half-full, 224/225 for almost-full, and 255/256 for full. An off-by-one comparison would flip a flag one word early or late.
- It counts how many writes fall-through mode accepts before blocking. A design that ignores the output register would stop at 256 instead of 257.
- It attempts writes while full and reads while empty. A design that lets the pointers move would then produce an extra word or corrupted words in the scoreboard.
- It loads two distinct thresholds. A swapped load order would move the almost-empty edge by hundreds of words.
- It toggles the mode input after reset. A design that samples it continuously would switch to request-driven output.

// File: rtl/dmf_pkg.sv
`timescale 1ns/1ps
package dmf_pkg;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} dmf_mode_e;

  // default threshold for a given RAM depth
  function automatic int dflt_ofs(input int depth);
    if (depth <= 256) return 31;
    else if (depth <= 512) return 63;
    else return 127;
  endfunction
endpackage

// File: rtl/dmf_gray_sync.sv
`timescale 1ns/1ps
module dmf_gray_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1, s2;

  function automatic logic [W-1:0] g2b(input logic [W-1:0] g);
    logic [W-1:0] b;
    for (int i = 0; i < W; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gray_in;
      s2 <= s1;
    end
  end

  assign bin_out = g2b(s2);
endmodule

// File: rtl/dmf_ram.sv
`timescale 1ns/1ps
module dmf_ram #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dmf_wr_ctl.sv
`timescale 1ns/1ps
module dmf_wr_ctl
  import dmf_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DEF_OFS = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_in,
  input  logic          wr_en,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic [AW:0]   rptr_bin,
  output logic [AW:0]   wptr_gray,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [AW-1:0] ae_ofs,
  output logic          wr_flag,
  output logic          af_n,
  output logic          hf_n
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

  dmf_mode_e     mode_q;
  logic [AW:0]   wptr, wcnt, wptr_nx, wcnt_nx, free_nx;
  logic [AW-1:0] af_ofs;
  logic          full, wr_ok, ld_sel;

  assign wcnt      = wptr - rptr_bin;
  assign full      = (wcnt == DEPTH_V);
  assign wr_ok     = wr_en & ~ld & ~full;
  assign wptr_nx   = wptr + {{AW{1'b0}}, wr_ok};
  assign wcnt_nx   = wptr_nx - rptr_bin;
  assign free_nx   = DEPTH_V - wcnt_nx;
  assign ram_we    = wr_ok;
  assign ram_waddr = wptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= dmf_mode_e'(mode_in);
      wptr      <= '0;
      wptr_gray <= '0;
      ld_sel    <= 1'b0;
      ae_ofs    <= AW'(DEF_OFS);
      af_ofs    <= AW'(DEF_OFS);
      wr_flag   <= 1'b1;
      af_n      <= 1'b1;
      hf_n      <= 1'b1;
    end else begin
      wptr      <= wptr_nx;
      wptr_gray <= wptr_nx ^ (wptr_nx >> 1);
      if (ld && wr_en) begin
        if (!ld_sel) ae_ofs <= ld_val;
        else         af_ofs <= ld_val;
        ld_sel <= ~ld_sel;
      end
      wr_flag <= (mode_q == MODE_FWFT) ? (wcnt_nx == DEPTH_V) : (wcnt_nx != DEPTH_V);
      af_n    <= ~(free_nx <= {1'b0, af_ofs});
      hf_n    <= ~(wcnt_nx > (DEPTH_V >> 1));
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= DEPTH_V);
  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> $stable(wptr));
  // R12
  wgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($countones(wptr_gray ^ $past(wptr_gray)) <= 1));
  // R1
  wmode_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
endmodule

// File: rtl/dmf_rd_ctl.sv
`timescale 1ns/1ps
module dmf_rd_ctl
  import dmf_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_in,
  input  logic          rd_en,
  input  logic [AW:0]   wptr_bin,
  input  logic [DW-1:0] ram_rdata,
  input  logic [AW-1:0] ae_ofs,
  output logic [AW:0]   rptr_gray,
  output logic [AW-1:0] ram_raddr,
  output logic [DW-1:0] rd_data,
  output logic          rd_flag,
  output logic          ae_n
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

  dmf_mode_e   mode_q;
  logic [AW:0] rptr, rcnt, rptr_nx, rcnt_nx, lvl_nx;
  logic        fwft, ov, ov_nx, ram_empty, fetch, rd_ok, ram_rd;

  assign fwft      = (mode_q == MODE_FWFT);
  assign rcnt      = wptr_bin - rptr;
  assign ram_empty = (rcnt == '0);
  assign rd_ok     = rd_en & ~ram_empty;
  assign fetch     = ~ram_empty & (~ov | rd_en);
  assign ram_rd    = fwft ? fetch : rd_ok;
  assign ov_nx     = fwft & (fetch | (ov & ~rd_en));
  assign rptr_nx   = rptr + {{AW{1'b0}}, ram_rd};
  assign rcnt_nx   = wptr_bin - rptr_nx;
  assign lvl_nx    = rcnt_nx + {{AW{1'b0}}, ov_nx};
  assign ram_raddr = rptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= dmf_mode_e'(mode_in);
      rptr      <= '0;
      rptr_gray <= '0;
      ov        <= 1'b0;
      rd_data   <= '0;
      rd_flag   <= mode_in;
      ae_n      <= 1'b0;
    end else begin
      rptr      <= rptr_nx;
      rptr_gray <= rptr_nx ^ (rptr_nx >> 1);
      ov        <= ov_nx;
      if (ram_rd) rd_data <= ram_rdata;
      rd_flag   <= fwft ? ~ov_nx : (rcnt_nx != '0);
      ae_n      <= ~(lvl_nx <= {1'b0, ae_ofs});
    end
  end

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= DEPTH_V);
  // R2
  std_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && !rd_en) |=> $stable(rd_data));
  // R3
  fall_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft && !ov && !ram_empty) |=> (ov && !rd_flag));
  // R12
  rgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($countones(rptr_gray ^ $past(rptr_gray)) <= 1));
  // R1
  rmode_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));
endmodule

// File: rtl/dual_mode_fifo.sv
`timescale 1ns/1ps
module dual_mode_fifo
  import dmf_pkg::*;
#(
  parameter int DW      = 18,
  parameter int AW      = 8,
  parameter int DEF_OFS = dflt_ofs(1 << AW)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          mode_fwft,
  input  logic          wr_en,
  input  logic          ld,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  output logic          wr_flag,
  output logic          rd_flag,
  output logic          ae_n,
  output logic          af_n,
  output logic          hf_n
);
  logic [AW:0]   wptr_gray, rptr_gray, wptr_in_r, rptr_in_w;
  logic          ram_we;
  logic [AW-1:0] ram_waddr, ram_raddr, ae_ofs;
  logic [DW-1:0] ram_rdata;

  dmf_gray_sync #(.W(AW+1)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .gray_in(wptr_gray), .bin_out(wptr_in_r));

  dmf_gray_sync #(.W(AW+1)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .gray_in(rptr_gray), .bin_out(rptr_in_w));

  dmf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(ram_we), .waddr(ram_waddr), .wdata(wdata),
    .raddr(ram_raddr), .rdata(ram_rdata));

  dmf_wr_ctl #(.AW(AW), .DEF_OFS(DEF_OFS)) u_wr (
    .clk(wclk), .rst_n(rst_n), .mode_in(mode_fwft), .wr_en(wr_en), .ld(ld),
    .ld_val(wdata[AW-1:0]), .rptr_bin(rptr_in_w), .wptr_gray(wptr_gray),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ae_ofs(ae_ofs),
    .wr_flag(wr_flag), .af_n(af_n), .hf_n(hf_n));

  dmf_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
    .clk(rclk), .rst_n(rst_n), .mode_in(mode_fwft), .rd_en(rd_en),
    .wptr_bin(wptr_in_r), .ram_rdata(ram_rdata), .ae_ofs(ae_ofs),
    .rptr_gray(rptr_gray), .ram_raddr(ram_raddr), .rd_data(rdata),
    .rd_flag(rd_flag), .ae_n(ae_n));
endmodule

// File: tb/dual_mode_fifo_tb.sv
`timescale 1ns/1ps
module dual_mode_fifo_tb;
  localparam int DW = 18;
  localparam int AW = 8;

  logic wclk = 0, rclk = 0, rst_n = 0, mode = 0;
  logic wr_en = 0, ld = 0, force_rd = 0, mon_rd = 0, rd_en;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic wr_flag, rd_flag, ae_n, af_n, hf_n;

  int errors = 0, checks = 0, nxt = 'h100;
  bit cur_mode = 0, rd_go = 0, pend = 0;
  logic [DW-1:0] q[$];

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;
  assign rd_en = force_rd | mon_rd;

  dual_mode_fifo #(.DW(DW), .AW(AW)) u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .mode_fwft(mode),
    .wr_en(wr_en), .ld(ld), .wdata(wdata), .rd_en(rd_en), .rdata(rdata),
    .wr_flag(wr_flag), .rd_flag(rd_flag), .ae_n(ae_n), .af_n(af_n), .hf_n(hf_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit space();
    return cur_mode ? !wr_flag : wr_flag;
  endfunction

  // monitor: reads by the flag protocol and compares with the queue (R12)
  always @(negedge rclk) begin
    logic [DW-1:0] exp;
    if (pend) begin
      pend = 0;
      if (q.size() == 0) check(0, "R12", int'(rdata), 0);
      else begin
        exp = q.pop_front();
        check(rdata == exp, "R12", int'(rdata), int'(exp));
      end
    end
    mon_rd = 0;
    if (rd_go && rst_n) begin
      if (!cur_mode) begin
        if (rd_flag && q.size() > 0) begin mon_rd = 1; pend = 1; end
      end else if (!rd_flag) begin
        if (q.size() == 0) check(0, "R3", int'(rdata), 0);
        else begin
          exp = q.pop_front();
          check(rdata == exp, "R12", int'(rdata), int'(exp));
          mon_rd = 1;
        end
      end
    end
  end

  task automatic settle();
    repeat (12) @(negedge rclk);
    repeat (4) @(negedge wclk);
  endtask

  task automatic push_words(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      while (!space()) begin wr_en = 0; @(negedge wclk); end
      wr_en = 1; wdata = DW'(nxt); q.push_back(DW'(nxt)); nxt++;
    end
    @(negedge wclk) wr_en = 0;
  endtask

  task automatic fill_count(output int cnt);
    int idle = 0;
    cnt = 0;
    while (idle < 20) begin
      @(negedge wclk);
      if (space()) begin
        wr_en = 1; wdata = DW'(nxt); q.push_back(DW'(nxt)); nxt++; cnt++; idle = 0;
      end else begin
        wr_en = 0; idle++;
      end
    end
    wr_en = 0;
  endtask

  task automatic drain();
    @(posedge rclk) rd_go = 1;
    while (q.size() > 0 || pend) @(negedge rclk);
    @(posedge rclk) rd_go = 0;
    settle();
  endtask

  task automatic force_write_full();
    @(negedge wclk) begin wr_en = 1; wdata = 'h3FFFF; end
    repeat (3) @(negedge wclk);
    wr_en = 0;
  endtask

  task automatic do_reset(input bit m);
    rst_n = 0; mode = m; cur_mode = m; rd_go = 0; q.delete();
    repeat (6) @(negedge rclk);
    check(wr_flag == 1, "R6", int'(wr_flag), 1);
    check(rd_flag == m, "R6", int'(rd_flag), int'(m));
    @(negedge wclk) rst_n = 1;
    settle();
    check(wr_flag == m ? 1'b0 : 1'b1, "R6", int'(wr_flag), int'(!m));
    check(rd_flag == m, "R6", int'(rd_flag), int'(m));
    check(rdata == 0, "R6", int'(rdata), 0);
    check(ae_n == 0, "R6", int'(ae_n), 0);
    check(af_n == 1 && hf_n == 1, "R6", int'({af_n, hf_n}), 3);
  endtask

  initial begin
    int cnt;
    // ---- standard mode ----
    do_reset(0);
    // R2: word not shown until a read
    @(negedge wclk) begin wr_en = 1; wdata = 'h1234; end
    @(negedge wclk) wr_en = 0;
    settle();
    check(rd_flag == 1, "R2", int'(rd_flag), 1);
    check(rdata == 0, "R2", int'(rdata), 0);
    @(negedge rclk) force_rd = 1;
    @(negedge rclk) force_rd = 0;
    check(rdata == 'h1234, "R2", int'(rdata), 'h1234);
    settle();
    // R5: reads while empty do nothing
    @(negedge rclk) force_rd = 1;
    repeat (5) @(negedge rclk);
    force_rd = 0;
    check(rdata == 'h1234, "R5", int'(rdata), 'h1234);
    check(rd_flag == 0, "R5", int'(rd_flag), 0);
    push_words(1); settle();
    check(rd_flag == 1, "R5", int'(rd_flag), 1);
    drain();
    // R7 R9 R10 R11 R4 level thresholds
    push_words(31); settle(); check(ae_n == 0, "R7", int'(ae_n), 0);
    push_words(1);  settle(); check(ae_n == 1, "R9", int'(ae_n), 1);
    push_words(96); settle(); check(hf_n == 1, "R11", int'(hf_n), 1);
    push_words(1);  settle(); check(hf_n == 0, "R11", int'(hf_n), 0);
    push_words(95); settle(); check(af_n == 1, "R10", int'(af_n), 1);
    push_words(1);  settle(); check(af_n == 0, "R10", int'(af_n), 0);
    push_words(30); settle(); check(wr_flag == 1, "R4", int'(wr_flag), 1);
    push_words(1);  settle(); check(wr_flag == 0, "R4", int'(wr_flag), 0);
    force_write_full(); settle();
    check(wr_flag == 0, "R5", int'(wr_flag), 0);
    drain();
    check(rd_flag == 0, "R5", int'(rd_flag), 0);
    check(wr_flag == 1, "R4", int'(wr_flag), 1);
    // R8 threshold load order
    @(negedge wclk) begin ld = 1; wr_en = 1; wdata = 5; end
    @(negedge wclk) wdata = 250;
    @(negedge wclk) begin ld = 0; wr_en = 0; end
    settle();
    check(rd_flag == 0, "R8", int'(rd_flag), 0);
    push_words(5); settle();
    check(ae_n == 0, "R8", int'(ae_n), 0);
    check(af_n == 1, "R8", int'(af_n), 1);
    push_words(1); settle();
    check(ae_n == 1, "R8", int'(ae_n), 1);
    check(af_n == 0, "R8", int'(af_n), 0);
    drain();
    // R12 streaming
    @(posedge rclk) rd_go = 1;
    push_words(300);
    drain();

    // ---- fall-through mode ----
    do_reset(1);
    push_words(1); settle();
    check(rd_flag == 0, "R3", int'(rd_flag), 0);
    check(rdata == q[0], "R3", int'(rdata), int'(q[0]));
    mode = 0; settle();  // R1: input change after reset ignored
    check(rd_flag == 0, "R1", int'(rd_flag), 0);
    check(rdata == q[0], "R1", int'(rdata), int'(q[0]));
    push_words(30); settle(); check(ae_n == 0, "R7", int'(ae_n), 0);
    push_words(1);  settle(); check(ae_n == 1, "R7", int'(ae_n), 1);
    fill_count(cnt);
    check(cnt + 32 == 257, "R4", cnt + 32, 257);
    check(wr_flag == 1, "R4", int'(wr_flag), 1);
    force_write_full(); settle();
    drain();
    check(rd_flag == 1, "R5", int'(rd_flag), 1);
    @(posedge rclk) rd_go = 1;
    push_words(400);
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk);
    checks++; errors++;
    $display("FAIL R12 watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule